// File: doc/BRIEF.md
# Link Fast-Reset Controller

This block sequences a warm reset for a buffer device sitting in a daisy chain of point-to-point serial links. Once the links have been trained at least once, electrical idle on the primary downstream-direction receiver asks for a fast reset. The controller then does four things in order:

- It passes idle on to the next device down the chain, unless this device is the last one.
- It forces the upstream transmitters to send zeros.
- It asks an external DRAM quiesce sequencer to bring the memory into a safe state, and waits for it to report done.
- It asserts reset on the non-sticky registers, commits pending configuration fields into their current copies, and resets the clock outputs of the still-locked PLL so that they realign.

After that, a device that is not last waits until idle comes back on its secondary upstream receiver, which shows that the devices behind it have finished. It then forwards idle upstream for a fixed window and releases. The last device in the chain skips that wait.

The pad reset input clears the controller asynchronously at any time. After a release, the controller does not re-arm until the downstream idle indication has gone away, so one long idle period produces only one fast reset.

Top module: `link_fast_reset`

## Requirements
- R1: While pad reset is low, and right after it, every output is low.
- R2: A sequence starts only when the trained flag is high and downstream idle is high at the same clock edge. Downstream idle while untrained leaves every output low.
- R3: Downstream idle forwarding is high from the cycle after the trigger until release, and only when the last-in-chain strap is low.
- R4: Upstream zero-forcing is high from the cycle after the trigger until upstream idle forwarding begins, and never at the same time as it.
- R5: The quiesce request is high from the cycle after the trigger and stays high until quiesce done is sampled high. Register reset is never high while the quiesce request is pending.
- R6: Register reset and clock realign rise in the cycle after quiesce done is sampled. Clock realign lasts exactly RESET_CYCLES cycles.
- R7: The commit strobe is high for exactly one cycle, which is the first cycle of clock realign.
- R8: A device that is not last keeps register reset high after the realign window and does not forward idle upstream until upstream idle is sampled high. Upstream idle forwarding then starts the next cycle.
- R9: The last device in the chain begins upstream idle forwarding in the cycle right after the realign window. It ignores upstream idle.
- R10: Upstream idle forwarding lasts FWD_CYCLES cycles, with register reset held throughout. After that, every output goes low (release).
- R11: After a release, no new sequence starts until downstream idle has been sampled low.
- R12: Pad reset going low in the middle of a sequence drives every output low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Pad reset, active low, asynchronous assert |
| link_trained | input | 1 | Full link initialization has completed at least once |
| last_in_chain | input | 1 | Strap: this device is the last in the chain |
| dn_idle_det | input | 1 | Electrical idle seen on the primary downstream-direction link |
| up_idle_det | input | 1 | Electrical idle seen on the secondary upstream-direction link |
| quiesce_done | input | 1 | DRAM quiesce sequencer has finished |
| dn_idle_fwd | output | 1 | Drive idle on the secondary downstream transmitter |
| up_idle_fwd | output | 1 | Drive idle on the primary upstream transmitter |
| up_tx_zero | output | 1 | Force all-zero data on the upstream transmitters |
| quiesce_req | output | 1 | Request to the DRAM quiesce sequencer |
| soft_rst | output | 1 | Reset for non-sticky registers |
| commit_pulse | output | 1 | Copy pending fields into current fields |
| clk_realign | output | 1 | Reset the PLL clock outputs so they realign |

## Verification
The hardest situations to reach are the ones where inputs move at awkward moments:

- upstream idle arriving before or during the realign window, when it must be ignored;
- downstream idle that never drops after a release;
- the strap value deciding the path exactly at the end of the realign window.

Random stimulus with a fixed seed toggles the idle detectors, the done input and the trained flag, so these inputs land in every phase. A reference model in the bench follows along, and pad reset is pulsed periodically so the strap can be changed. Directed runs then hold upstream idle low to check the wait on a device that is not last, and check that the last device skips it. They also keep downstream idle stuck high after a release and pull pad reset mid-sequence.

// File: rtl/link_fast_reset.sv
module link_fast_reset #(
  parameter int RESET_CYCLES = 4,
  parameter int FWD_CYCLES   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_trained,
  input  logic last_in_chain,
  input  logic dn_idle_det,
  input  logic up_idle_det,
  input  logic quiesce_done,
  output logic dn_idle_fwd,
  output logic up_idle_fwd,
  output logic up_tx_zero,
  output logic quiesce_req,
  output logic soft_rst,
  output logic commit_pulse,
  output logic clk_realign
);

  localparam int MAXC = (RESET_CYCLES > FWD_CYCLES) ? RESET_CYCLES : FWD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_QUIESCE, ST_RESET, ST_WAIT_UP, ST_FWD_UP, ST_REARM
  } state_t;

  state_t state, state_nx;
  logic [CW-1:0] cnt;

  wire rst_end = (cnt == CW'(RESET_CYCLES - 1));
  wire fwd_end = (cnt == CW'(FWD_CYCLES - 1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (link_trained && dn_idle_det) state_nx = ST_QUIESCE;
      ST_QUIESCE: if (quiesce_done) state_nx = ST_RESET;
      ST_RESET:   if (rst_end) state_nx = last_in_chain ? ST_FWD_UP : ST_WAIT_UP;
      ST_WAIT_UP: if (up_idle_det) state_nx = ST_FWD_UP;
      ST_FWD_UP:  if (fwd_end) state_nx = ST_REARM;
      ST_REARM:   if (!dn_idle_det) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state)
        cnt <= '0;
      else if (state == ST_RESET || state == ST_FWD_UP)
        cnt <= cnt + 1'b1;
    end
  end

  wire in_seq = (state == ST_QUIESCE) || (state == ST_RESET) ||
                (state == ST_WAIT_UP) || (state == ST_FWD_UP);

  assign dn_idle_fwd  = in_seq && !last_in_chain;
  assign up_idle_fwd  = (state == ST_FWD_UP);
  assign up_tx_zero   = (state == ST_QUIESCE) || (state == ST_RESET) || (state == ST_WAIT_UP);
  assign quiesce_req  = (state == ST_QUIESCE);
  assign soft_rst     = (state == ST_RESET) || (state == ST_WAIT_UP) || (state == ST_FWD_UP);
  assign clk_realign  = (state == ST_RESET);
  assign commit_pulse = (state == ST_RESET) && (cnt == '0);

  AST_REGRST_AFTER_QUIESCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(quiesce_req && quiesce_done)); // R5
  AST_QREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesce_req && !quiesce_done) |=> quiesce_req); // R5
  AST_NO_REGRST_IN_QUIESCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(quiesce_req && soft_rst)); // R5
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse); // R7
  AST_COMMIT_IN_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (soft_rst && clk_realign)); // R7
  AST_ZERO_VS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_tx_zero && up_idle_fwd)); // R4
  AST_DN_FWD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dn_idle_fwd |-> !last_in_chain); // R3
  AST_UP_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_idle_fwd) |-> ($past(last_in_chain) || $past(up_idle_det))); // R8
  AST_UP_FWD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    up_idle_fwd |-> soft_rst); // R10

endmodule

// File: tb/tb_link_fast_reset.sv
module tb_link_fast_reset;
  localparam int RC = 4;
  localparam int FC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_trained = 1'b0, last_in_chain = 1'b0;
  logic dn_idle_det = 1'b0, up_idle_det = 1'b0, quiesce_done = 1'b0;
  logic dn_idle_fwd, up_idle_fwd, up_tx_zero, quiesce_req, soft_rst, commit_pulse, clk_realign;

  int checks = 0, failures = 0;
  bit done = 0;
  int ph = 0, pcnt = 0;

  always #2.5 clk = ~clk;

  link_fast_reset #(.RESET_CYCLES(RC), .FWD_CYCLES(FC)) dut (
    .clk(clk), .rst_n(rst_n), .link_trained(link_trained), .last_in_chain(last_in_chain),
    .dn_idle_det(dn_idle_det), .up_idle_det(up_idle_det), .quiesce_done(quiesce_done),
    .dn_idle_fwd(dn_idle_fwd), .up_idle_fwd(up_idle_fwd), .up_tx_zero(up_tx_zero),
    .quiesce_req(quiesce_req), .soft_rst(soft_rst), .commit_pulse(commit_pulse),
    .clk_realign(clk_realign));

  // Reference phases: 0 idle, 1 quiesce, 2 realign, 3 wait upstream, 4 forward upstream, 5 re-arm
  always @(posedge clk) begin
    if (!rst_n) begin ph = 0; pcnt = 0; end
    else case (ph)
      0: if (link_trained && dn_idle_det) ph = 1;
      1: if (quiesce_done) begin ph = 2; pcnt = 0; end
      2: if (pcnt == RC-1) begin ph = last_in_chain ? 4 : 3; pcnt = 0; end else pcnt++;
      3: if (up_idle_det) begin ph = 4; pcnt = 0; end
      4: if (pcnt == FC-1) begin ph = 5; pcnt = 0; end else pcnt++;
      default: if (!dn_idle_det) ph = 0;
    endcase
  end

  function automatic logic [6:0] expect_out(int p, int c, logic last);
    logic seq = (p >= 1) && (p <= 4);
    return {seq && !last, p == 4, p >= 1 && p <= 3, p == 1, p >= 2 && p <= 4,
            p == 2 && c == 0, p == 2};
  endfunction

  function automatic string bit_tag(int b);
    case (b)
      6: return "R3 dn_idle_fwd";
      5: return "R8/R10 up_idle_fwd";
      4: return "R4 up_tx_zero";
      3: return "R5 quiesce_req";
      2: return "R6 soft_rst";
      1: return "R7 commit_pulse";
      default: return "R6 clk_realign";
    endcase
  endfunction

  function automatic logic [6:0] outs();
    return {dn_idle_fwd, up_idle_fwd, up_tx_zero, quiesce_req, soft_rst, commit_pulse, clk_realign};
  endfunction

  initial begin
    forever begin
      @(posedge clk); #2;
      begin
        logic [6:0] e = expect_out(ph, pcnt, last_in_chain);
        logic [6:0] a = outs();
        checks++;
        if (a !== e) begin
          failures++;
          for (int b = 6; b >= 0; b--)
            if (a[b] !== e[b])
              $display("FAIL %s actual=%b expected=%b phase=%0d t=%0t", bit_tag(b), a[b], e[b], ph, $time);
        end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pad_reset(logic last);
    @(negedge clk); rst_n = 1'b0; last_in_chain = last;
    link_trained = 0; dn_idle_det = 0; up_idle_det = 0; quiesce_done = 0;
    cyc(2); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd4177));
    cyc(2);
    check("R1 outputs low in reset", |outs(), 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 outputs low after reset", |outs(), 1'b0);

    // R2: idle while untrained is ignored
    link_trained = 0; dn_idle_det = 1; cyc(10);
    check("R2 untrained idle ignored", |outs(), 1'b0);
    dn_idle_det = 0;

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) pad_reset($urandom % 2);
      @(negedge clk);
      link_trained = ($urandom % 16) != 0;
      dn_idle_det  = ($urandom % 3) == 0;
      up_idle_det  = ($urandom % 4) == 0;
      quiesce_done = ($urandom % 4) == 0;
    end

    // R8: not last, waits for upstream idle
    pad_reset(1'b0);
    link_trained = 1; dn_idle_det = 1; cyc(1); dn_idle_det = 0;
    cyc(2); quiesce_done = 1; cyc(1); quiesce_done = 0;
    cyc(RC + 20);
    check("R8 no upstream forward before upstream idle", up_idle_fwd, 1'b0);
    check("R8 register reset held while waiting", soft_rst, 1'b1);
    up_idle_det = 1; cyc(1); up_idle_det = 0;
    #3 check("R8 upstream forward after upstream idle", up_idle_fwd, 1'b1);
    cyc(FC + 2);
    check("R10 released after forward window", |outs(), 1'b0);

    // R9: last device skips the wait; R11: no retrigger while idle stays high
    pad_reset(1'b1);
    link_trained = 1; dn_idle_det = 1; quiesce_done = 1;
    seen = 0;
    for (int k = 0; k < RC + 4; k++) begin
      @(posedge clk); #2; if (up_idle_fwd) seen = 1;
    end
    check("R9 last device forwards upstream without upstream idle", seen, 1'b1);
    cyc(FC + 10);
    check("R11 no retrigger while downstream idle stays high", |outs(), 1'b0);
    dn_idle_det = 0; cyc(1); dn_idle_det = 1; cyc(2);
    #3 check("R11 retrigger after downstream idle drop", up_tx_zero, 1'b1);

    // R12: pad reset mid-sequence
    @(negedge clk); #1 rst_n = 1'b0; #0.5;
    check("R12 abort clears soft_rst", soft_rst | quiesce_req | up_tx_zero, 1'b0);
    cyc(2); dn_idle_det = 0; rst_n = 1'b1; cyc(3);
    check("R12 stays idle after abort", |outs(), 1'b0);

    finish_run();
  end
endmodule